// File: doc/BRIEF.md
# Reference-to-Synthesizer Frequency Lock Monitor

This block tells whether a synthesized clock runs at the frequency its reference asks for. It receives the reference clock and the parallel-rate clock. The parallel-rate clock is the synthesized clock divided by four, and it enters the block as a plain digital input. Over a fixed window of reference cycles, the block counts the edges of the parallel-rate clock and compares that count with the count a locked loop would produce. It then drives an active-low flag: the flag is low while the loop is judged out of lock and high while it is judged locked.

The reference may run at the parallel rate or at 1/4, 1/8 or 1/16 of it, chosen by a two-bit select. The expected count and both thresholds scale with the selected ratio, so the block judges the same relative error at every setting. Hysteresis separates the two decisions. A large error (500 ppm by default) drops the flag. The flag rises again only when the error falls under a smaller bound (250 ppm by default). Any error between the two bounds keeps the previous verdict.

The parallel-rate count crosses into the reference domain once per window through a request/acknowledge toggle pair. The count register is frozen before the acknowledge is seen, so the value crosses safely.

Top module: `freq_lock_mon`

## Requirements
- R1: While `rst_n` is low, and directly after it is released, `lock_fail_n` is 0 (unlocked).
- R2: After reset, the window that starts at reset release is only used to align the two domains. `lock_fail_n` can first rise at the end of the second window, and only if that window meets the regain bound.
- R3: At the end of a window, if the absolute gap between the parallel-clock count and the expected count exceeds the loss limit, `lock_fail_n` goes to 0. This holds whether the synthesized clock is fast or slow.
- R4: If the gap is at least the regain limit and no more than the loss limit, `lock_fail_n` keeps its previous value, whether that value is 0 or 1. The output changes at no time other than a window evaluation.
- R5: If the gap at the end of a window is below the regain limit, `lock_fail_n` goes to 1.
- R6: `rate_sel` encoding: 0 means the reference runs at the parallel rate (ratio 1); 1 means ratio 4; 2 means ratio 8; 3 means ratio 16. The expected count is 2^WIN_LOG2 times the ratio, and both limits are multiplied by the ratio.
- R7: A window is 2^WIN_LOG2 reference cycles. The base limits are round(2^WIN_LOG2 × ppm / 10^6) for LOSS_PPM and for REGAIN_PPM. The defaults give 33 and 16.
- R8: The parallel-clock counter saturates at its maximum and does not wrap, so a count too large for the register is still judged a loss.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_ref | input | 1 | Reference clock; the window and the verdict live in this domain |
| clk_par | input | 1 | Synthesized clock divided by four (parallel-rate clock) |
| rst_n | input | 1 | Asynchronous active-low reset for both domains |
| rate_sel | input | 2 | Reference-to-parallel ratio select (0:1, 1:4, 2:8, 3:16) |
| lock_fail_n | output | 1 | Active-low loss-of-lock flag; 1 means locked |

## Verification
On every reference cycle, the assertions check that the verdict follows the gap and limits computed inside the block. A gap above the loss limit forces the flag low, a gap below the regain limit forces it high, and a gap in the band, or the absence of an evaluation, leaves it unchanged. They also check that the flag stays low until the alignment window is over and that the parallel counter holds at its ceiling. Only the bench's scenarios can show that real clocks with a known frequency offset give the right verdict. This covers the per-ratio scaling of the expected count and the limits, the plus and minus error cases, a mismatched select, and the size of the counter overflow region.

// File: rtl/lockdet_pkg.sv
package lockdet_pkg;

  // Count equivalent of a ppm figure over a window, rounded to nearest.
  function automatic logic [31:0] ppm_to_count(input logic [31:0] win, input logic [31:0] ppm);
    logic [63:0] prod;
    prod = {32'd0, win} * {32'd0, ppm} + 64'd500000;
    return 32'(prod / 64'd1000000);
  endfunction

  // Left shift equal to log2 of the reference-to-parallel ratio.
  function automatic logic [2:0] ratio_shift(input logic [1:0] sel);
    case (sel)
      2'd0:    return 3'd0;
      2'd1:    return 3'd2;
      2'd2:    return 3'd3;
      default: return 3'd4;
    endcase
  endfunction

  function automatic logic [31:0] abs_gap(input logic [31:0] a, input logic [31:0] b);
    return (a >= b) ? (a - b) : (b - a);
  endfunction

endpackage

// File: rtl/lockdet_sync.sv
module lockdet_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] ff;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ff <= '0;
    else        ff <= {ff[STAGES-2:0], d};
  end

  assign q = ff[STAGES-1];
endmodule

// File: rtl/lockdet_refwin.sv
// Reference-domain window timer: toggles a request once per window.
module lockdet_refwin #(
  parameter int unsigned WIN_LOG2 = 16
) (
  input  logic clk_ref,
  input  logic rst_n,
  output logic req_tgl
);
  logic [WIN_LOG2-1:0] tick;

  always_ff @(posedge clk_ref or negedge rst_n) begin
    if (!rst_n) begin
      tick    <= '0;
      req_tgl <= 1'b0;
    end else begin
      tick <= tick + 1'b1;
      if (&tick) req_tgl <= ~req_tgl;
    end
  end
endmodule

// File: rtl/lockdet_parcnt.sv
// Parallel-domain edge counter with snapshot on each synchronized request.
module lockdet_parcnt #(
  parameter int unsigned CNT_W = 21
) (
  input  logic             clk_par,
  input  logic             rst_n,
  input  logic             req_tgl,
  output logic [CNT_W-1:0] snap,
  output logic             ack_tgl,
  output logic [CNT_W-1:0] cnt_o,
  output logic             take_o
);
  logic             req_s, req_d;
  logic [CNT_W-1:0] cnt;
  logic             take;

  lockdet_sync #(.STAGES(2)) u_req_sync (
    .clk(clk_par), .rst_n(rst_n), .d(req_tgl), .q(req_s)
  );

  assign take = req_s ^ req_d;

  always_ff @(posedge clk_par or negedge rst_n) begin
    if (!rst_n) begin
      req_d <= 1'b0;
      cnt   <= '0;
      snap  <= '0;
    end else begin
      req_d <= req_s;
      if (take) begin
        snap <= cnt;
        cnt  <= {{(CNT_W-1){1'b0}}, 1'b1};
      end else if (!(&cnt)) begin
        cnt <= cnt + 1'b1;
      end
    end
  end

  // Snapshot and acknowledge update on the same edge; snap is stable
  // long before the reference domain sees the acknowledge.
  assign ack_tgl = req_d;
  assign cnt_o   = cnt;
  assign take_o  = take;
endmodule

// File: rtl/lockdet_judge.sv
// Reference-domain verdict with hysteresis.
module lockdet_judge #(
  parameter int unsigned WIN_LOG2 = 16,
  parameter int unsigned CNT_W    = 21,
  parameter logic [31:0] LOSS_TH  = 32'd33,
  parameter logic [31:0] REGAIN_TH = 32'd16
) (
  input  logic             clk_ref,
  input  logic             rst_n,
  input  logic             ack_tgl,
  input  logic [CNT_W-1:0] snap,
  input  logic [1:0]       rate_sel,
  output logic             lock_ok,
  output logic             eval_stb,
  output logic             primed,
  output logic [31:0]      gap,
  output logic [31:0]      loss_lim,
  output logic [31:0]      regain_lim
);
  import lockdet_pkg::*;

  localparam logic [31:0] WIN = 32'd1 << WIN_LOG2;

  logic        ack_s, ack_d, ev;
  logic [2:0]  shift;
  logic [31:0] expect_cnt;

  lockdet_sync #(.STAGES(2)) u_ack_sync (
    .clk(clk_ref), .rst_n(rst_n), .d(ack_tgl), .q(ack_s)
  );

  assign ev         = ack_s ^ ack_d;
  assign eval_stb   = ev & primed;
  assign shift      = ratio_shift(rate_sel);
  assign expect_cnt = WIN << shift;
  assign gap        = abs_gap({{(32-CNT_W){1'b0}}, snap}, expect_cnt);
  assign loss_lim   = LOSS_TH << shift;
  assign regain_lim = REGAIN_TH << shift;

  always_ff @(posedge clk_ref or negedge rst_n) begin
    if (!rst_n) begin
      ack_d   <= 1'b0;
      primed  <= 1'b0;
      lock_ok <= 1'b0;
    end else begin
      ack_d <= ack_s;
      if (ev) begin
        if (!primed)                primed  <= 1'b1;
        else if (gap > loss_lim)    lock_ok <= 1'b0;
        else if (gap < regain_lim)  lock_ok <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/freq_lock_mon.sv
module freq_lock_mon #(
  parameter int unsigned WIN_LOG2   = 16,
  parameter int unsigned LOSS_PPM   = 500,
  parameter int unsigned REGAIN_PPM = 250
) (
  input  logic       clk_ref,
  input  logic       clk_par,
  input  logic       rst_n,
  input  logic [1:0] rate_sel,
  output logic       lock_fail_n
);
  import lockdet_pkg::*;

  localparam int unsigned CNT_W     = WIN_LOG2 + 5;
  localparam logic [31:0] WIN       = 32'd1 << WIN_LOG2;
  localparam logic [31:0] LOSS_TH   = ppm_to_count(WIN, 32'(LOSS_PPM));
  localparam logic [31:0] REGAIN_TH = ppm_to_count(WIN, 32'(REGAIN_PPM));

  logic             req_tgl, ack_tgl, take, eval_stb, primed, lock_ok;
  logic [CNT_W-1:0] snap, par_cnt;
  logic [31:0]      gap, loss_lim, regain_lim;

  lockdet_refwin #(.WIN_LOG2(WIN_LOG2)) u_win (
    .clk_ref(clk_ref), .rst_n(rst_n), .req_tgl(req_tgl)
  );

  lockdet_parcnt #(.CNT_W(CNT_W)) u_cnt (
    .clk_par(clk_par), .rst_n(rst_n), .req_tgl(req_tgl),
    .snap(snap), .ack_tgl(ack_tgl), .cnt_o(par_cnt), .take_o(take)
  );

  lockdet_judge #(
    .WIN_LOG2(WIN_LOG2), .CNT_W(CNT_W),
    .LOSS_TH(LOSS_TH), .REGAIN_TH(REGAIN_TH)
  ) u_judge (
    .clk_ref(clk_ref), .rst_n(rst_n), .ack_tgl(ack_tgl), .snap(snap),
    .rate_sel(rate_sel), .lock_ok(lock_ok), .eval_stb(eval_stb),
    .primed(primed), .gap(gap), .loss_lim(loss_lim), .regain_lim(regain_lim)
  );

  assign lock_fail_n = lock_ok;
endmodule

// File: rtl/lockdet_checker.sv
module lockdet_checker #(
  parameter int unsigned CNT_W = 21
) (
  input logic             clk_ref,
  input logic             clk_par,
  input logic             rst_n,
  input logic             eval_stb,
  input logic             primed,
  input logic             lock_fail_n,
  input logic [31:0]      gap,
  input logic [31:0]      loss_lim,
  input logic [31:0]      regain_lim,
  input logic [CNT_W-1:0] par_cnt,
  input logic             take
);
  assert_start_low_R2: assert property (@(posedge clk_ref) disable iff (!rst_n)
    !primed |-> !lock_fail_n);

  assert_loss_R3: assert property (@(posedge clk_ref) disable iff (!rst_n)
    (eval_stb && gap > loss_lim) |=> !lock_fail_n);

  assert_band_hold_R4: assert property (@(posedge clk_ref) disable iff (!rst_n)
    (eval_stb && gap >= regain_lim && gap <= loss_lim) |=> $stable(lock_fail_n));

  assert_no_eval_hold_R4: assert property (@(posedge clk_ref) disable iff (!rst_n)
    !eval_stb |=> $stable(lock_fail_n));

  assert_regain_R5: assert property (@(posedge clk_ref) disable iff (!rst_n)
    (eval_stb && gap < regain_lim && gap <= loss_lim) |=> lock_fail_n);

  assert_count_saturate_R8: assert property (@(posedge clk_par) disable iff (!rst_n)
    (!take && (&par_cnt)) |=> (&par_cnt));
endmodule

bind freq_lock_mon lockdet_checker #(.CNT_W(CNT_W)) u_chk (
  .clk_ref(clk_ref), .clk_par(clk_par), .rst_n(rst_n),
  .eval_stb(eval_stb), .primed(primed), .lock_fail_n(lock_fail_n),
  .gap(gap), .loss_lim(loss_lim), .regain_lim(regain_lim),
  .par_cnt(par_cnt), .take(take)
);

// File: tb/sim_freq_lock_mon.sv
`timescale 1ps/1ps
module sim_freq_lock_mon;
  // Bench window 2^10 = 1024; 40000/20000 ppm give limits
  // (1024*40000+500000)/1e6 = 41 and (1024*20000+500000)/1e6 = 20 (R7).
  // Offset e gives a gap of about 1024*ratio*e: 3% -> 30.7*ratio (band),
  // 8% -> 82*ratio (loss), 0% -> ~0 (regain).
  localparam int W = 1024;

  logic       clk_ref = 1'b0;
  logic       clk_par = 1'b0;
  logic       rst_n   = 1'b0;
  logic [1:0] rate_sel = 2'd0;
  logic       lock_fail_n;
  real        ref_half = 2000.0;
  int         nchk = 0;
  int         nbad = 0;
  bit         done = 1'b0;

  freq_lock_mon #(.WIN_LOG2(10), .LOSS_PPM(40000), .REGAIN_PPM(20000)) u0 (
    .clk_ref(clk_ref), .clk_par(clk_par), .rst_n(rst_n),
    .rate_sel(rate_sel), .lock_fail_n(lock_fail_n)
  );

  always #2000 clk_par = ~clk_par;             // 250 MHz
  always begin #(ref_half) clk_ref = ~clk_ref; end

  task automatic set_ref(input int ratio, input int err_permille);
    ref_half = 2000.0 * ratio * (1.0 + err_permille / 1000.0);
  endtask

  task automatic wait_ref(input int n);
    repeat (n) @(posedge clk_ref);
    #100;
  endtask

  task automatic check(input logic act, input logic exp, input string req);
    nchk++;
    if (act !== exp) begin
      nbad++;
      $display("FAIL %s lock_fail_n=%0b expected %0b", req, act, exp);
    end
  endtask

  task automatic t_reset;
    set_ref(1, 0); rate_sel = 2'd0; rst_n = 1'b0;
    wait_ref(20);  check(lock_fail_n, 1'b0, "R1 in reset");
    rst_n = 1'b1;
    wait_ref(5);   check(lock_fail_n, 1'b0, "R1 after release");
  endtask

  task automatic t_first_window;
    wait_ref(W / 2 + W);  check(lock_fail_n, 1'b0, "R2 alignment window");
    wait_ref(W / 2 + 16); check(lock_fail_n, 1'b1, "R2 R5 first lock");
  endtask

  task automatic t_band_hold_high;
    set_ref(1, 30);
    for (int i = 0; i < 3; i++) begin
      wait_ref(W); check(lock_fail_n, 1'b1, "R4 band keeps locked");
    end
  endtask

  task automatic t_loss_fast;
    set_ref(1, 80);
    wait_ref(2 * W + 16); check(lock_fail_n, 1'b0, "R3 loss fast synth");
  endtask

  task automatic t_band_hold_low;
    set_ref(1, 30);
    for (int i = 0; i < 3; i++) begin
      wait_ref(W); check(lock_fail_n, 1'b0, "R4 band keeps unlocked");
    end
  endtask

  task automatic t_regain;
    set_ref(1, 0);
    wait_ref(2 * W + 16); check(lock_fail_n, 1'b1, "R5 regain");
  endtask

  task automatic t_loss_slow;
    set_ref(1, -80);
    wait_ref(2 * W + 16); check(lock_fail_n, 1'b0, "R3 loss slow synth");
    set_ref(1, 0);
    wait_ref(2 * W + 16); check(lock_fail_n, 1'b1, "R5 regain after slow");
  endtask

  task automatic t_ratio4;
    rate_sel = 2'd1; set_ref(4, 0);
    wait_ref(2 * W + 16); check(lock_fail_n, 1'b1, "R6 ratio 4 lock");
    set_ref(4, 30);       // gap ~123: inside scaled band [80,164]
    wait_ref(2 * W + 16); check(lock_fail_n, 1'b1, "R6 ratio 4 scaled band");
    set_ref(4, 80);       // gap ~328 > 164
    wait_ref(2 * W + 16); check(lock_fail_n, 1'b0, "R6 ratio 4 loss");
  endtask

  task automatic t_ratio8_and_mismatch;
    rate_sel = 2'd2; set_ref(8, 0);
    wait_ref(2 * W + 16); check(lock_fail_n, 1'b1, "R6 ratio 8 lock");
    rate_sel = 2'd0;      // expects 1024, sees 8192
    wait_ref(W + 16);     check(lock_fail_n, 1'b0, "R6 select mismatch");
    set_ref(1, 0);
    wait_ref(2 * W + 16); check(lock_fail_n, 1'b1, "R6 ratio 1 relock");
  endtask

  task automatic t_saturate;
    // 33x slow reference: 33792 edges exceed the 15-bit counter; a wrap
    // would leave 1024 (false lock), saturation leaves 32767 (loss).
    set_ref(33, 0);
    wait_ref(2 * W + 4); check(lock_fail_n, 1'b0, "R8 saturated count is loss");
  endtask

  initial begin
    t_reset();
    t_first_window();
    t_band_hold_high();
    t_loss_fast();
    t_band_hold_low();
    t_regain();
    t_loss_slow();
    t_ratio4();
    t_ratio8_and_mismatch();
    t_saturate();
    if (!done) begin
      done = 1'b1;
      $display("  test done: total=%0d bad=%0d", nchk, nbad);
      $finish;
    end
  end

  initial begin
    repeat (195000) @(posedge clk_par);
    if (!done) begin
      done = 1'b1;
      nchk++; nbad++;
      $display("FAIL watchdog expired lock_fail_n=%0b expected completion", lock_fail_n);
      $display("  test done: total=%0d bad=%0d", nchk, nbad);
      $finish;
    end
  end
endmodule